// File: doc/BRIEF.md
# Divider reconfiguration write sequencer

This block reprograms the counter fields of a clock synthesizer through its reconfiguration port. It takes one start request carrying three divider settings: an integer input divider, a feedback multiplier in eighths and an output divider in eighths. The request also carries the lock-detector fields and the loop-filter word, which some other agent has already worked out. The sequencer turns each divider into its counter fields: high count, low count, odd-edge flag, bypass flag, fractional enable, fraction, rising and falling waveform flags and fractional phase. It then issues a fixed list of thirteen masked register updates.

A masked update whose mask does not cover all sixteen bits is carried out as a read-modify-write. The engine reads the register, keeps the bits outside the mask, merges in the new bits and writes the word back. A one-cycle `start` begins the update and a one-cycle `done` ends it. A request with a zero divider is rejected at once and touches nothing.

Top module: `clkcfg_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `done`, `err` and `cfg_en` are all 0.
- R2: A `start` with a zero `in_div`, `fb_mult` or `out_div` sets `done` and `err` for one cycle, in the cycle after `start`. No port access follows.
- R3: A valid request produces exactly thirteen writes, to these addresses in this order:
  - 0x28
  - 0x08, 0x09 and 0x07 (output divider)
  - 0x16 (input divider)
  - 0x14, 0x15 and 0x13 (feedback divider)
  - 0x18, 0x19 and 0x1A (lock)
  - 0x4E and 0x4F (filter)

  `cfg_en` is only ever high while `busy` is high.
- R4: Every write is preceded by a read of the same address. The written word equals (old & ~mask) | (value & mask). `cfg_en` is a single-cycle pulse.
- R5: Divider word layouts, bit positions given:
  - Word A is high<<6 | low, under mask 0xEFFF.
  - Word B is frac<<12 | frac_en<<11 | rise<<10 | edge<<7 | bypass<<6, under mask 0x7FFF.
  - Word C is phase<<11 | fall<<10, under mask 0x3C00.
  - The input divider word is edge<<13 | bypass<<12 | high<<6 | low, under mask 0x3FFF.
  - For the output and feedback dividers, words A, B and C go to the first, second and third address of that divider's group in R3. The input divider uses the single word.
- R6: An integer part of 1 gives only bypass = 1, whatever the fraction. Any other integer N with fraction 0 gives high = N/2, edge = N mod 2 and low = N - high. The input divider always has fraction 0.
- R7: With fraction f ≠ 0:
  - frac_en = 1, frac = f, and high and low both start from N/2, with edge = N mod 2.
  - When edge is 0, high is reduced by one and rise is set.
  - Low is reduced by one when edge is 0 or f = 1.
  - fall = ((edge = 0) xor (f = 1)) or (N = 2 and f = 1).
  - phase = edge*4 + f/2.

  The multiplier and output divider values are N = value>>3 and f = value & 7.
- R8: The write to 0x28 carries 0x9800 under mask 0x9800 when the multiplier or the output divider has a nonzero fraction. Otherwise it carries 0 under the same mask.
- R9: The lock and filter writes carry these values:
  - 0x18 takes `lock_cnt` under mask 0x3FF.
  - 0x19 takes `lock_ref`<<10 | 1 under mask 0x7FFF.
  - 0x1A takes `lock_sat`<<10 | 0x3E9 under mask 0x7FFF.
  - 0x4E and 0x4F take the upper and lower halves of `filt_word`, each under mask 0x9900.
- R10: `busy` is high from the cycle after an accepted `start` until the final write is acknowledged. `done` is a one-cycle pulse in the cycle after the last write's `cfg_rdy`.
- R11: A `start` seen while `busy` is high is ignored. The running sequence keeps the values it latched, and no further sequence follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, sampled when idle |
| in_div | input | D_W | Input divider, integer |
| fb_mult | input | M_W | Feedback multiplier in eighths |
| out_div | input | O_W | Output divider in eighths |
| lock_cnt | input | 10 | Lock count field |
| lock_ref | input | 5 | Lock reference field |
| lock_sat | input | 5 | Lock saturation field |
| filt_word | input | 32 | Loop filter word, upper half to 0x4E |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 1 | Rejected request, valid with done |
| cfg_en | output | 1 | Port access strobe |
| cfg_we | output | 1 | Access is a write |
| cfg_addr | output | AW | Register address |
| cfg_wdata | output | DW | Write data |
| cfg_rdata | input | DW | Read data, valid with cfg_rdy |
| cfg_rdy | input | 1 | Access acknowledge |

## Verification
A rejected request has a fixed latency: `done` and `err` are due in the cycle right after `start`. The bench samples that edge alone, then watches four more cycles for any port strobe. A valid request's writes come at a pace set by the port's acknowledge latency, which the bench model varies between 0 and 2 cycles.

Each expected write therefore sits in an ordered queue and is compared at the write strobe itself. The expected data is built from the model's register copy at that moment. `done` is due exactly one cycle after the acknowledge of the thirteenth write. The bench records the cycle of each acknowledge and checks the `done` edge against it, then confirms that `done` and `busy` are low one cycle later.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
   // register map of the synthesizer's reconfiguration space
   localparam logic [6:0] A_PWR = 7'h28;
   localparam logic [6:0] A_O1  = 7'h08;
   localparam logic [6:0] A_O2  = 7'h09;
   localparam logic [6:0] A_O3  = 7'h07;
   localparam logic [6:0] A_IN  = 7'h16;
   localparam logic [6:0] A_F1  = 7'h14;
   localparam logic [6:0] A_F2  = 7'h15;
   localparam logic [6:0] A_F3  = 7'h13;
   localparam logic [6:0] A_LK1 = 7'h18;
   localparam logic [6:0] A_LK2 = 7'h19;
   localparam logic [6:0] A_LK3 = 7'h1A;
   localparam logic [6:0] A_FL1 = 7'h4E;
   localparam logic [6:0] A_FL2 = 7'h4F;

   localparam int unsigned N_STEPS = 13;
   localparam int unsigned STEP_W  = 4;
   localparam int unsigned WORD_W  = 16;
endpackage

// File: rtl/clkcfg_div_enc.sv
module clkcfg_div_enc
   import clkcfg_pkg::*;
#(
   parameter int unsigned VW        = 11,
   parameter int unsigned FRAC_BITS = 3,
   localparam int unsigned IW = VW - FRAC_BITS,
   localparam int unsigned NW = (FRAC_BITS == 0) ? 1 : 3
)(
   input  logic [VW-1:0]        v,
   output logic [NW*WORD_W-1:0] words
);
   if (FRAC_BITS != 0 && FRAC_BITS != 3) begin : g_bad_frac
      $error("clkcfg_div_enc: FRAC_BITS must be 0 or 3");
   end
   if (IW < 2) begin : g_bad_iw
      $error("clkcfg_div_enc: integer part too narrow");
   end

   logic [IW-1:0] n;
   assign n = v[VW-1:FRAC_BITS];

   if (FRAC_BITS == 0) begin : g_int
      // single-word integer layout: edge<<13 | bypass<<12 | high<<6 | low
      logic [IW-1:0] h, l;
      logic          e, byp;
      always_comb begin
         h   = '0;
         l   = '0;
         e   = 1'b0;
         byp = 1'b0;
         if (n == IW'(1)) begin
            byp = 1'b1;
         end else begin
            h = n >> 1;
            e = n[0];
            l = n - h;
         end
         words = {2'b00, e, byp, 6'(h), 6'(l)};
      end
   end else begin : g_frac
      // three-word layout with fractional flags
      logic [2:0]    f;
      logic [IW-1:0] h, l;
      logic          e, byp, fen, wr, wf;
      logic [2:0]    ph;
      logic [15:0]   wa, wb, wc;
      assign f = v[2:0];
      always_comb begin
         h   = '0;
         l   = '0;
         e   = 1'b0;
         byp = 1'b0;
         fen = 1'b0;
         wr  = 1'b0;
         wf  = 1'b0;
         ph  = 3'd0;
         if (n == IW'(1)) begin
            byp = 1'b1;
         end else if (f == 3'd0) begin
            h = n >> 1;
            e = n[0];
            l = n - h;
         end else begin
            fen = 1'b1;
            h   = n >> 1;
            e   = n[0];
            l   = h;
            if (!e) begin
               h  = h - 1'b1;
               wr = 1'b1;
            end
            if (!e || f == 3'd1) l = l - 1'b1;
            wf = ((!e) ^ (f == 3'd1)) || (n == IW'(2) && f == 3'd1);
            ph = {e, f[2:1]};
         end
         wa = {4'b0000, 6'(h), 6'(l)};
         wb = {1'b0, (fen ? f : 3'd0), fen, wr, 2'b00, e, byp, 6'b0};
         wc = {2'b00, ph, wf, 10'b0};
         words = {wc, wb, wa};
      end
   end
endmodule

// File: rtl/clkcfg_steps.sv
module clkcfg_steps
   import clkcfg_pkg::*;
#(
   parameter int unsigned AW = 7,
   parameter int unsigned DW = 16
)(
   input  logic [STEP_W-1:0]   step,
   input  logic [3*WORD_W-1:0] out_w,
   input  logic [WORD_W-1:0]   in_w,
   input  logic [3*WORD_W-1:0] fb_w,
   input  logic                frac_any,
   input  logic [9:0]          lock_cnt,
   input  logic [4:0]          lock_ref,
   input  logic [4:0]          lock_sat,
   input  logic [31:0]         filt_word,
   output logic [AW-1:0]       addr,
   output logic [DW-1:0]       val,
   output logic [DW-1:0]       mask
);
   logic [6:0]  a;
   logic [15:0] v, m;

   always_comb begin
      a = 7'h00;
      v = 16'h0000;
      m = 16'h0000;
      case (step)
         4'd0:  begin a = A_PWR; v = frac_any ? 16'h9800 : 16'h0000; m = 16'h9800; end
         4'd1:  begin a = A_O1;  v = out_w[15:0];  m = 16'hEFFF; end
         4'd2:  begin a = A_O2;  v = out_w[31:16]; m = 16'h7FFF; end
         4'd3:  begin a = A_O3;  v = out_w[47:32]; m = 16'h3C00; end
         4'd4:  begin a = A_IN;  v = in_w;         m = 16'h3FFF; end
         4'd5:  begin a = A_F1;  v = fb_w[15:0];   m = 16'hEFFF; end
         4'd6:  begin a = A_F2;  v = fb_w[31:16];  m = 16'h7FFF; end
         4'd7:  begin a = A_F3;  v = fb_w[47:32];  m = 16'h3C00; end
         4'd8:  begin a = A_LK1; v = {6'b0, lock_cnt};          m = 16'h03FF; end
         4'd9:  begin a = A_LK2; v = {1'b0, lock_ref, 10'h001}; m = 16'h7FFF; end
         4'd10: begin a = A_LK3; v = {1'b0, lock_sat, 10'h3E9}; m = 16'h7FFF; end
         4'd11: begin a = A_FL1; v = filt_word[31:16]; m = 16'h9900; end
         4'd12: begin a = A_FL2; v = filt_word[15:0];  m = 16'h9900; end
         default: begin a = 7'h00; v = 16'h0000; m = 16'h0000; end
      endcase
   end

   assign addr = AW'(a);
   assign val  = DW'(v);
   assign mask = DW'(m);
endmodule

// File: rtl/clkcfg_rmw.sv
module clkcfg_rmw #(
   parameter int unsigned AW = 7,
   parameter int unsigned DW = 16
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] val_i,
   input  logic [DW-1:0] mask_i,
   output logic          ack,
   output logic          port_en,
   output logic          port_we,
   output logic [AW-1:0] port_addr,
   output logic [DW-1:0] port_wdata,
   input  logic [DW-1:0] port_rdata,
   input  logic          port_rdy
);
   typedef enum logic [2:0] {R_IDLE, R_RD, R_RDW, R_WR, R_WRW} rmw_st_t;
   rmw_st_t       st;
   logic [AW-1:0] a_q;
   logic [DW-1:0] v_q, m_q, w_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= R_IDLE;
         a_q <= '0;
         v_q <= '0;
         m_q <= '0;
         w_q <= '0;
      end else begin
         case (st)
            R_IDLE: if (go) begin
               a_q <= addr_i;
               v_q <= val_i & mask_i;
               m_q <= mask_i;
               w_q <= val_i;
               st  <= (&mask_i) ? R_WR : R_RD;
            end
            R_RD:  st <= R_RDW;
            R_RDW: if (port_rdy) begin
               w_q <= (port_rdata & ~m_q) | v_q;
               st  <= R_WR;
            end
            R_WR:  st <= R_WRW;
            R_WRW: if (port_rdy) st <= R_IDLE;
            default: st <= R_IDLE;
         endcase
      end
   end

   assign port_en    = (st == R_RD) || (st == R_WR);
   assign port_we    = (st == R_WR);
   assign port_addr  = a_q;
   assign port_wdata = w_q;
   assign ack        = (st == R_WRW) && port_rdy;

   // R4
   en_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      port_en |=> !port_en);
endmodule

// File: rtl/clkcfg_seq.sv
module clkcfg_seq
   import clkcfg_pkg::*;
#(
   parameter int unsigned AW  = 7,
   parameter int unsigned DW  = 16,
   parameter int unsigned D_W = 8,
   parameter int unsigned M_W = 10,
   parameter int unsigned O_W = 11
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [D_W-1:0] in_div,
   input  logic [M_W-1:0] fb_mult,
   input  logic [O_W-1:0] out_div,
   input  logic [9:0]     lock_cnt,
   input  logic [4:0]     lock_ref,
   input  logic [4:0]     lock_sat,
   input  logic [31:0]    filt_word,
   output logic           busy,
   output logic           done,
   output logic           err,
   output logic           cfg_en,
   output logic           cfg_we,
   output logic [AW-1:0]  cfg_addr,
   output logic [DW-1:0]  cfg_wdata,
   input  logic [DW-1:0]  cfg_rdata,
   input  logic           cfg_rdy
);
   localparam logic [STEP_W-1:0] LAST = STEP_W'(N_STEPS - 1);

   if (AW < 7) begin : g_bad_aw
      $error("clkcfg_seq: AW must cover 7-bit register addresses");
   end
   if (DW != WORD_W) begin : g_bad_dw
      $error("clkcfg_seq: DW must equal the 16-bit register width");
   end
   if (M_W < 5 || O_W < 5 || D_W < 2) begin : g_bad_div
      $error("clkcfg_seq: divider inputs too narrow");
   end
   if ((1 << STEP_W) < N_STEPS) begin : g_bad_step
      $error("clkcfg_seq: step counter too narrow");
   end

   typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} seq_st_t;
   seq_st_t           st;
   logic [STEP_W-1:0] step;
   logic [D_W-1:0]    d_q;
   logic [M_W-1:0]    m_q;
   logic [O_W-1:0]    o_q;
   logic [9:0]        lc_q;
   logic [4:0]        lr_q, ls_q;
   logic [31:0]       fw_q;
   logic              go, ack;

   logic [3*WORD_W-1:0] out_w, fb_w;
   logic [WORD_W-1:0]   in_w;
   logic [AW-1:0]       s_addr;
   logic [DW-1:0]       s_val, s_mask;
   logic                frac_any;

   clkcfg_div_enc #(.VW(O_W), .FRAC_BITS(3)) u_enc_out (.v(o_q), .words(out_w));
   clkcfg_div_enc #(.VW(D_W), .FRAC_BITS(0)) u_enc_in  (.v(d_q), .words(in_w));
   clkcfg_div_enc #(.VW(M_W), .FRAC_BITS(3)) u_enc_fb  (.v(m_q), .words(fb_w));

   assign frac_any = (|o_q[2:0]) || (|m_q[2:0]);

   clkcfg_steps #(.AW(AW), .DW(DW)) u_steps (
      .step(step), .out_w(out_w), .in_w(in_w), .fb_w(fb_w),
      .frac_any(frac_any), .lock_cnt(lc_q), .lock_ref(lr_q),
      .lock_sat(ls_q), .filt_word(fw_q),
      .addr(s_addr), .val(s_val), .mask(s_mask)
   );

   clkcfg_rmw #(.AW(AW), .DW(DW)) u_rmw (
      .clk(clk), .rst_n(rst_n), .go(go),
      .addr_i(s_addr), .val_i(s_val), .mask_i(s_mask), .ack(ack),
      .port_en(cfg_en), .port_we(cfg_we), .port_addr(cfg_addr),
      .port_wdata(cfg_wdata), .port_rdata(cfg_rdata), .port_rdy(cfg_rdy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= S_IDLE;
         step <= '0;
         d_q  <= '0;
         m_q  <= '0;
         o_q  <= '0;
         lc_q <= '0;
         lr_q <= '0;
         ls_q <= '0;
         fw_q <= '0;
         done <= 1'b0;
         err  <= 1'b0;
      end else begin
         done <= 1'b0;
         err  <= 1'b0;
         case (st)
            S_IDLE: if (start) begin
               if (in_div == '0 || fb_mult == '0 || out_div == '0) begin
                  done <= 1'b1;
                  err  <= 1'b1;
               end else begin
                  d_q  <= in_div;
                  m_q  <= fb_mult;
                  o_q  <= out_div;
                  lc_q <= lock_cnt;
                  lr_q <= lock_ref;
                  ls_q <= lock_sat;
                  fw_q <= filt_word;
                  step <= '0;
                  st   <= S_ISSUE;
               end
            end
            S_ISSUE: st <= S_WAIT;
            S_WAIT: if (ack) begin
               if (step == LAST) begin
                  st   <= S_IDLE;
                  done <= 1'b1;
               end else begin
                  step <= step + 1'b1;
                  st   <= S_ISSUE;
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign go   = (st == S_ISSUE);
   assign busy = (st != S_IDLE);

   // R2
   err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done);
   // R3
   port_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_en |-> busy);
   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R11
   hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> ($stable(d_q) && $stable(m_q) && $stable(o_q)));
   // R3
   step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (step <= LAST));
endmodule

// File: tb/sim_clkcfg_seq.sv
module sim_clkcfg_seq;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        start;
   logic [7:0]  in_div;
   logic [9:0]  fb_mult;
   logic [10:0] out_div;
   logic [9:0]  lock_cnt;
   logic [4:0]  lock_ref, lock_sat;
   logic [31:0] filt_word;
   logic        busy, done, err, cfg_en, cfg_we;
   logic [6:0]  cfg_addr;
   logic [15:0] cfg_wdata;
   logic [15:0] cfg_rdata;
   logic        cfg_rdy;

   always #10 clk = ~clk;

   clkcfg_seq u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .in_div(in_div),
      .fb_mult(fb_mult), .out_div(out_div), .lock_cnt(lock_cnt),
      .lock_ref(lock_ref), .lock_sat(lock_sat), .filt_word(filt_word),
      .busy(busy), .done(done), .err(err), .cfg_en(cfg_en), .cfg_we(cfg_we),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .cfg_rdy(cfg_rdy)
   );

   typedef struct {
      logic [6:0]  a;
      logic [15:0] v;
      logic [15:0] m;
      string       rq;
   } exp_t;

   exp_t        q[$];
   exp_t        e_cur;
   logic [15:0] want;
   logic [15:0] shadow [128];
   int checks = 0, fails = 0, cyc = 0, lat = 0, ops = 0, writes = 0, last_rdy = 0;
   int cnt = 0;
   logic       pend = 1'b0, pwe = 1'b0;
   logic [6:0] pa = '0, last_rd = '1;
   logic [15:0] pd = '0;

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, expv);
      end
   endtask

   // reference field encoding, from R6 and R7
   function automatic void enc(input int n, input int f,
      output int hi, output int lo, output int ed, output int nc, output int fe,
      output int fr, output int wr, output int wf, output int ph);
      hi = 0; lo = 0; ed = 0; nc = 0; fe = 0; fr = 0; wr = 0; wf = 0; ph = 0;
      if (n == 1) nc = 1;
      else if (f == 0) begin
         hi = n / 2; ed = n % 2; lo = n - hi;
      end else begin
         fe = 1; fr = f; hi = n / 2; ed = n % 2; lo = hi;
         if (ed == 0) begin hi = hi - 1; wr = 1; end
         if (ed == 0 || f == 1) lo = lo - 1;
         wf = (((ed == 0) != (f == 1)) || (n == 2 && f == 1)) ? 1 : 0;
         ph = ed * 4 + f / 2;
      end
      hi = hi & 63; lo = lo & 63;
   endfunction

   function automatic void push(input int a, input int v, input int m, input string rq);
      exp_t x;
      x.a = a[6:0]; x.v = v[15:0]; x.m = m[15:0]; x.rq = rq;
      q.push_back(x);
   endfunction

   function automatic void push_div3(input int n, input int f, input int a1,
                                     input int a2, input int a3);
      int hi, lo, ed, nc, fe, fr, wr, wf, ph;
      enc(n, f, hi, lo, ed, nc, fe, fr, wr, wf, ph);
      push(a1, (hi << 6) | lo, 'hEFFF, "R5");
      push(a2, (fr << 12) | (fe << 11) | (wr << 10) | (ed << 7) | (nc << 6), 'h7FFF, "R5");
      push(a3, (ph << 11) | (wf << 10), 'h3C00, "R5");
   endfunction

   function automatic void build(input int d, input int m, input int o,
      input int lc, input int lr, input int ls, input int fw);
      int hi, lo, ed, nc, fe, fr, wr, wf, ph;
      push('h28, ((m & 7) != 0 || (o & 7) != 0) ? 'h9800 : 0, 'h9800, "R8");
      push_div3(o >> 3, o & 7, 'h08, 'h09, 'h07);
      enc(d, 0, hi, lo, ed, nc, fe, fr, wr, wf, ph);
      push('h16, (ed << 13) | (nc << 12) | (hi << 6) | lo, 'h3FFF, "R6");
      push_div3(m >> 3, m & 7, 'h14, 'h15, 'h13);
      push('h18, lc, 'h03FF, "R9");
      push('h19, (lr << 10) | 1, 'h7FFF, "R9");
      push('h1A, (ls << 10) | 'h3E9, 'h7FFF, "R9");
      push('h4E, (fw >> 16) & 'hFFFF, 'h9900, "R9");
      push('h4F, fw & 'hFFFF, 'h9900, "R9");
   endfunction

   always @(posedge clk) cyc++;

   // port model and scoreboard monitor
   always @(negedge clk) begin
      cfg_rdy = 1'b0;
      if (pend) begin
         if (cnt == 0) begin
            cfg_rdy = 1'b1;
            last_rdy = cyc;
            if (pwe) shadow[pa] = pd;
            else cfg_rdata = shadow[pa];
            pend = 1'b0;
         end else cnt--;
      end
      if (cfg_en) begin
         ops++;
         pend = 1'b1; cnt = lat; pa = cfg_addr; pwe = cfg_we; pd = cfg_wdata;
         if (cfg_we) begin
            writes++;
            if (q.size() == 0) chk(1'b0, "R3", "unexpected write address", 32'(cfg_addr), 0);
            else begin
               e_cur = q.pop_front();
               want = (shadow[cfg_addr] & ~e_cur.m) | (e_cur.v & e_cur.m);
               chk(cfg_addr == e_cur.a, "R3", "write address", 32'(cfg_addr), 32'(e_cur.a));
               chk(last_rd == cfg_addr, "R4", "read before write", 32'(last_rd), 32'(cfg_addr));
               chk(cfg_wdata == want, e_cur.rq, "write data", 32'(cfg_wdata), 32'(want));
            end
         end else last_rd = cfg_addr;
      end
   end

   task automatic run_cfg(input int d, input int m, input int o, input int lc,
      input int lr, input int ls, input int fw, input bit poke);
      int w0, waited, ops1;
      w0 = writes; waited = 0;
      build(d, m, o, lc, lr, ls, fw);
      in_div = d[7:0]; fb_mult = m[9:0]; out_div = o[10:0];
      lock_cnt = lc[9:0]; lock_ref = lr[4:0]; lock_sat = ls[4:0]; filt_word = fw;
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(busy == 1'b1, "R10", "busy after start", 32'(busy), 1);
      while (!done && waited < 3000) begin
         @(negedge clk); waited++;
         if (poke && waited == 6) begin
            in_div = 8'd7; fb_mult = 10'd99; out_div = 11'd200; start = 1'b1;  // R11
         end else if (poke && waited == 7) start = 1'b0;
      end
      chk(done == 1'b1, "R10", "done seen", 32'(done), 1);
      chk(cyc == last_rdy + 1, "R10", "done one cycle after last ack", cyc, last_rdy + 1);
      chk(err == 1'b0, "R2", "no error on valid request", 32'(err), 0);
      chk(writes - w0 == 13, "R3", "write count", writes - w0, 13);
      chk(q.size() == 0, "R3", "expected writes left", q.size(), 0);
      @(negedge clk);
      chk(!done && !busy, "R10", "done single cycle, busy low", {done, busy}, 0);
      if (poke) begin
         ops1 = ops;
         repeat (8) @(negedge clk);
         chk(ops == ops1 && !busy, "R11", "no sequence from start while busy", ops - ops1, 0);
      end
   endtask

   task automatic err_case(input int d, input int m, input int o);
      int ops0;
      ops0 = ops;
      in_div = d[7:0]; fb_mult = m[9:0]; out_div = o[10:0];
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(done && err, "R2", "done and err after zero divider", {done, err}, 3);
      repeat (4) @(negedge clk);
      chk(ops == ops0 && !busy, "R2", "no port access on rejected request", ops - ops0, 0);
   endtask

   initial begin
      for (int i = 0; i < 128; i++) shadow[i] = 16'(i * 'h9E37) ^ 16'h5A5A;
      cfg_rdata = '0; cfg_rdy = 1'b0;
      rst_n = 1'b0; start = 1'b0; in_div = '0; fb_mult = '0; out_div = '0;
      lock_cnt = '0; lock_ref = '0; lock_sat = '0; filt_word = '0;
      repeat (3) @(negedge clk);
      chk({busy, done, err, cfg_en} == 4'b0, "R1", "outputs in reset", {busy, done, err, cfg_en}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({busy, done, err, cfg_en} == 4'b0, "R1", "outputs after reset", {busy, done, err, cfg_en}, 0);
      // R6: input divider of 1, integer multiplier and output divider, power word 0 (R8)
      lat = 0; run_cfg(1, 64, 32, 'h3E8, 'h06, 'h06, 'h0100_1990, 1'b0);
      // R7: output f=1 with even integer, multiplier f=3 odd integer
      lat = 2; run_cfg(3, 43, 49, 'h339, 'h1F, 'h1F, 'h0800_9090, 1'b0);
      // R7: output N=2 f=1, multiplier f=4 odd; R11 start while busy
      lat = 1; run_cfg(2, 60, 17, 'h2EE, 'h0B, 'h1C, 'h0100_8890, 1'b1);
      // R6: output integer 1 bypass, multiplier fractional f=2
      lat = 0; run_cfg(5, 74, 8, 'h0FA, 'h11, 'h0E, 'h0800_1090, 1'b0);
      // R2: each zero divider rejected
      err_case(0, 64, 32);
      err_case(4, 0, 32);
      err_case(4, 64, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(20 * 150000);
      checks++; fails++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule